// File: doc/BRIEF.md
# AUX Request Framer with Retry Policy

This block turns one link-auxiliary-channel command into the request header that a lower channel engine sends, and then decides what to do with each completion that engine returns. Four command kinds are handled: native write, native read, I2C-over-AUX write and I2C-over-AUX read. The requester presents the kind, a 16-bit address, a payload length, a stop flag, a single I2C write byte and the size of its receive buffer. The block answers with a one-cycle done pulse, an error class, a byte count and, for I2C reads, the byte that was read.

Between the first attempt and the final answer the block owns the whole retry policy. A busy completion is re-sent at once. A deferral waits a fixed pause that is derived from the clock frequency. Timeouts, channel errors and negative acknowledgements end the command. No command ever uses more than four attempts. Only one command is in flight at a time, and the line coding and electrical layer sit below the channel interface.

Top module: `auxreq_engine`

## Requirements
- R1: `ch_hdr[7:0]` carries address bits 7:0 and `ch_hdr[15:8]` carries address bits 15:8. Byte 2 (`ch_hdr[23:16]`) has the command code in bits 7:4: native write 8, native read 9, I2C write 0, I2C read 1. Kind encoding on `req_kind` is 0 native write, 1 native read, 2 I2C write, 3 I2C read.
- R2: Byte 3 (`ch_hdr[31:24]`) holds the low four bits of the total message length in its upper nibble and the payload length minus one in its lower nibble. Total length is payload+4 for a native write, 4 for a native read, 5 for an I2C write (byte 3 = 0x50) and 4 for an I2C read (byte 3 = 0x40). Byte 4 is the write byte for an I2C write and 0 otherwise. `ch_msg_len` is the total length.
- R3: A native write with length above 16 is never sent. `done` rises on the cycle after the request, with `res_err` = 5 and no `ch_start`.
- R4: Completion status 2 (busy) starts a new attempt on the cycle after `ch_done`. Status 1 ends with `res_err` = 1 (timeout). Status 3 ends with `res_err` = 2 (I/O error).
- R5: When status is 0 and native reply field `ch_reply[1:0]` is 2 (defer), the block waits exactly CLK_MHZ*WAIT_US idle cycles after the completion cycle, and `ch_start` rises on the next cycle.
- R6: Native reply code 1 (NACK) or code 3 ends a native command with `res_err` = 2 and an I2C command with `res_err` = 4 (remote I/O).
- R7: A command makes at most 4 attempts. If busy or defer is still pending after the fourth attempt, a native command ends with `res_err` = 2 and an I2C command with `res_err` = 4.
- R8: For I2C commands whose stop flag is 0, command bit 2 (middle of transaction, byte 2 bit 6) is set. With the stop flag at 1 it is clear.
- R9: The I2C reply field `ch_reply[3:2]` is used only when the native field is ACK (0). Its codes are 0 ACK, 1 NACK (ends with `res_err` = 4), 2 defer (waits as in R5, then retries) and 3 (ends with `res_err` = 4). `res_byte` is `ch_rdata` only on an I2C read that ends with I2C ACK, and 0 in every other case.
- R10: On success `res_count` is min(`ch_rcount`, `req_bufsz`), except for a native write, which reports the request length. On any error `res_count` is 0.
- R11: A native read that is acknowledged with a clamped count of zero ends with `res_err` = 3 (protocol error).
- R12: `done` is a single-cycle pulse. It rises on the cycle after the deciding `ch_done`, and the result outputs hold until the next request. After reset `done`, `ch_start` and `res_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command request strobe, honoured when idle |
| req_kind | input | 2 | Command kind (R1 encoding) |
| req_addr | input | 16 | Target address |
| req_len | input | LEN_W | Payload length in bytes |
| req_stop | input | 1 | I2C stop flag |
| req_wdata | input | 8 | Byte for an I2C write |
| req_bufsz | input | LEN_W | Requester receive buffer size |
| ch_start | output | 1 | One-cycle pulse: send the header |
| ch_hdr | output | 40 | Header bytes, byte 0 in bits 7:0 |
| ch_msg_len | output | LEN_W+1 | Total message length |
| ch_done | input | 1 | Channel completion strobe |
| ch_status | input | 2 | Completion status |
| ch_reply | input | 8 | Reply byte (native and I2C fields) |
| ch_rdata | input | 8 | First received data byte |
| ch_rcount | input | LEN_W | Received data count |
| done | output | 1 | Command finished pulse |
| res_err | output | 3 | Error class, 0 is success |
| res_count | output | LEN_W | Result byte count |
| res_byte | output | 8 | Byte returned by an I2C read |

## Verification
The assertions assume that `ch_done` rises only while an attempt is outstanding, at least one cycle after its `ch_start`. They also assume that `req_valid` comes only while no command is in flight. The bench's channel model answers every header with exactly one completion a fixed two cycles later and never raises an unsolicited one. Requests are issued only after the previous `done` has been observed. Each command's replies are scripted in advance from a queue, so busy, defer, NACK and exhaustion sequences stay inside these assumptions.

// File: rtl/auxreq_pkg.sv
// Shared encodings for the AUX request framer: command kinds, result
// classes, completion and reply codes. Assumes nothing beyond 1800-2017.
package auxreq_pkg;

    typedef enum logic [1:0] {
        K_NWR = 2'd0,
        K_NRD = 2'd1,
        K_IWR = 2'd2,
        K_IRD = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        E_OK      = 3'd0,
        E_TIMEOUT = 3'd1,
        E_IO      = 3'd2,
        E_PROTO   = 3'd3,
        E_REMOTE  = 3'd4,
        E_TOOBIG  = 3'd5
    } res_err_e;

    typedef enum logic [1:0] {
        A_FINISH = 2'd0,
        A_RETRY  = 2'd1,
        A_DEFER  = 2'd2
    } act_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_SEND  = 3'd1,
        S_WAIT  = 3'd2,
        S_PAUSE = 3'd3,
        S_FIN   = 3'd4
    } fsm_e;

    localparam logic [3:0] CMD_NWR = 4'h8;
    localparam logic [3:0] CMD_NRD = 4'h9;
    localparam logic [3:0] CMD_IWR = 4'h0;
    localparam logic [3:0] CMD_IRD = 4'h1;
    localparam logic [3:0] CMD_MOT = 4'h4;

    localparam logic [1:0] ST_OK      = 2'd0;
    localparam logic [1:0] ST_TIMEOUT = 2'd1;
    localparam logic [1:0] ST_BUSY    = 2'd2;
    localparam logic [1:0] ST_ERROR   = 2'd3;

    localparam logic [1:0] RP_ACK   = 2'd0;
    localparam logic [1:0] RP_NACK  = 2'd1;
    localparam logic [1:0] RP_DEFER = 2'd2;

endpackage

// File: rtl/auxreq_hdr.sv
// Header builder: forms the five header bytes and the total message length
// from a latched command. Purely combinational.
// Assumes LEN_W >= 4 so that the length-minus-one nibble exists.
module auxreq_hdr
    import auxreq_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  req_kind_e          kind,
    input  logic [15:0]        addr,
    input  logic [LEN_W-1:0]   len,
    input  logic               stop,
    input  logic [7:0]         wdata,
    output logic [39:0]        hdr,
    output logic [LEN_W:0]     msg_len
);
    localparam int ML_W = LEN_W + 1;

    logic [3:0]       cmd;
    logic [7:0]       b3;
    logic [7:0]       b4;
    logic [LEN_W-1:0] lm1;

    assign lm1 = len - LEN_W'(1);

    // Select the command code, total length and trailing bytes per kind.
    always_comb begin
        cmd     = CMD_IWR;
        msg_len = ML_W'(4);
        b4      = 8'h00;
        case (kind)
            K_NWR: begin
                cmd     = CMD_NWR;
                msg_len = ML_W'(len) + ML_W'(4);
            end
            K_NRD: begin
                cmd     = CMD_NRD;
                msg_len = ML_W'(4);
            end
            K_IWR: begin
                cmd     = stop ? CMD_IWR : (CMD_IWR | CMD_MOT);
                msg_len = ML_W'(5);
                b4      = wdata;
            end
            default: begin
                cmd     = stop ? CMD_IRD : (CMD_IRD | CMD_MOT);
                msg_len = ML_W'(4);
            end
        endcase
        if (kind[1])
            b3 = {msg_len[3:0], 4'h0};
        else
            b3 = {msg_len[3:0], lm1[3:0]};
    end

    assign hdr = {b4, b3, cmd, 4'h0, addr[15:8], addr[7:0]};

endmodule

// File: rtl/auxreq_judge.sv
// Completion judge: classifies one channel completion into finish, retry or
// defer, and forms the error class, clamped count and read byte.
// Combinational; assumes its inputs are only meaningful while ch_done is high.
module auxreq_judge
    import auxreq_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  req_kind_e          kind,
    input  logic [LEN_W-1:0]   len,
    input  logic [LEN_W-1:0]   bufsz,
    input  logic [1:0]         status,
    input  logic [7:0]         reply,
    input  logic [7:0]         rdata,
    input  logic [LEN_W-1:0]   rcount,
    input  logic               last_try,
    output act_e               act,
    output res_err_e           err,
    output logic [LEN_W-1:0]   count,
    output logic [7:0]         rbyte
);
    logic [LEN_W-1:0] clamped;
    logic             native;
    res_err_e         reject_err;

    assign clamped    = (rcount > bufsz) ? bufsz : rcount;
    assign native     = ~kind[1];
    assign reject_err = native ? E_IO : E_REMOTE;

    // Decide the outcome of one attempt, then fold in the attempt limit.
    always_comb begin
        act   = A_FINISH;
        err   = E_OK;
        count = '0;
        rbyte = 8'h00;
        case (status)
            ST_TIMEOUT: err = E_TIMEOUT;
            ST_ERROR:   err = E_IO;
            ST_BUSY:    act = A_RETRY;
            default: begin
                case (reply[1:0])
                    RP_ACK: begin
                        if (kind == K_NWR) begin
                            count = len;
                        end else if (kind == K_NRD) begin
                            if (clamped == '0)
                                err = E_PROTO;
                            else
                                count = clamped;
                        end else begin
                            case (reply[3:2])
                                RP_ACK: begin
                                    count = clamped;
                                    if (kind == K_IRD)
                                        rbyte = rdata;
                                end
                                RP_DEFER: act = A_DEFER;
                                default:  err = E_REMOTE;
                            endcase
                        end
                    end
                    RP_DEFER: act = A_DEFER;
                    default:  err = reject_err;
                endcase
            end
        endcase
        if (act != A_FINISH && last_try) begin
            act   = A_FINISH;
            err   = reject_err;
            count = '0;
            rbyte = 8'h00;
        end
    end

endmodule

// File: rtl/auxreq_wait.sv
// Pause timer: after a load it counts CYC cycles and flags the last one.
// Assumes CYC >= 1; a load while running restarts the count.
module auxreq_wait #(
    parameter int CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    logic [CW-1:0] cnt;
    logic          running;

    // Down-counter from CYC-1 to zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= CW'(CYC - 1);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0)
                running <= 1'b0;
            else
                cnt <= cnt - CW'(1);
        end
    end

    assign expired = running && (cnt == '0);

endmodule

// File: rtl/auxreq_engine.sv
// AUX request framer with retry: latches one command, issues its header to
// the channel, judges each completion and re-sends on busy or after a pause
// on defer, for at most MAX_TRIES attempts. Assumes req_valid only while
// idle and ch_done only while an attempt is outstanding.
module auxreq_engine
    import auxreq_pkg::*;
#(
    parameter int LEN_W       = 5,
    parameter int MAX_TRIES   = 4,
    parameter int MAX_PAYLOAD = 16,
    parameter int CLK_MHZ     = 250,
    parameter int WAIT_US     = 400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [15:0]        req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               req_stop,
    input  logic [7:0]         req_wdata,
    input  logic [LEN_W-1:0]   req_bufsz,
    output logic               ch_start,
    output logic [39:0]        ch_hdr,
    output logic [LEN_W:0]     ch_msg_len,
    input  logic               ch_done,
    input  logic [1:0]         ch_status,
    input  logic [7:0]         ch_reply,
    input  logic [7:0]         ch_rdata,
    input  logic [LEN_W-1:0]   ch_rcount,
    output logic               done,
    output logic [2:0]         res_err,
    output logic [LEN_W-1:0]   res_count,
    output logic [7:0]         res_byte
);
    localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
    localparam int TW       = $clog2(MAX_TRIES + 1);
    localparam logic [LEN_W-1:0] PAYLOAD_LIM = LEN_W'(MAX_PAYLOAD);
    localparam logic [TW-1:0]    LAST_TRY    = TW'(MAX_TRIES - 1);

    fsm_e             st;
    req_kind_e        kind_q;
    logic [15:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic             stop_q;
    logic [7:0]       wdata_q;
    logic [LEN_W-1:0] bufsz_q;
    logic [TW-1:0]    tries;

    act_e             j_act;
    res_err_e         j_err;
    logic [LEN_W-1:0] j_count;
    logic [7:0]       j_byte;
    logic             pause_load;
    logic             pause_over;
    logic             too_big;

    assign too_big = (req_kind_e'(req_kind) == K_NWR) && (req_len > PAYLOAD_LIM);

    auxreq_hdr #(.LEN_W(LEN_W)) u_hdr (
        .kind    (kind_q),
        .addr    (addr_q),
        .len     (len_q),
        .stop    (stop_q),
        .wdata   (wdata_q),
        .hdr     (ch_hdr),
        .msg_len (ch_msg_len)
    );

    auxreq_judge #(.LEN_W(LEN_W)) u_judge (
        .kind     (kind_q),
        .len      (len_q),
        .bufsz    (bufsz_q),
        .status   (ch_status),
        .reply    (ch_reply),
        .rdata    (ch_rdata),
        .rcount   (ch_rcount),
        .last_try (tries == LAST_TRY),
        .act      (j_act),
        .err      (j_err),
        .count    (j_count),
        .rbyte    (j_byte)
    );

    assign pause_load = (st == S_WAIT) && ch_done && (j_act == A_DEFER);

    auxreq_wait #(.CYC(WAIT_CYC)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pause_load),
        .expired (pause_over)
    );

    // Command sequencer: accept, send, judge, pause and report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            kind_q    <= K_NWR;
            addr_q    <= '0;
            len_q     <= '0;
            stop_q    <= 1'b0;
            wdata_q   <= '0;
            bufsz_q   <= '0;
            tries     <= '0;
            res_err   <= '0;
            res_count <= '0;
            res_byte  <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        kind_q  <= req_kind_e'(req_kind);
                        addr_q  <= req_addr;
                        len_q   <= req_len;
                        stop_q  <= req_stop;
                        wdata_q <= req_wdata;
                        bufsz_q <= req_bufsz;
                        tries   <= '0;
                        if (too_big) begin
                            res_err   <= E_TOOBIG;
                            res_count <= '0;
                            res_byte  <= '0;
                            st        <= S_FIN;
                        end else begin
                            st <= S_SEND;
                        end
                    end
                end
                S_SEND: st <= S_WAIT;
                S_WAIT: begin
                    if (ch_done) begin
                        case (j_act)
                            A_RETRY: begin
                                tries <= tries + TW'(1);
                                st    <= S_SEND;
                            end
                            A_DEFER: begin
                                tries <= tries + TW'(1);
                                st    <= S_PAUSE;
                            end
                            default: begin
                                res_err   <= j_err;
                                res_count <= j_count;
                                res_byte  <= j_byte;
                                st        <= S_FIN;
                            end
                        endcase
                    end
                end
                S_PAUSE: begin
                    if (pause_over)
                        st <= S_SEND;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign ch_start = (st == S_SEND);
    assign done     = (st == S_FIN);

endmodule

// File: rtl/auxreq_chk.sv
// Checker for auxreq_engine: watches ports only and tracks its own view of
// attempts and pause lengths. Assumes the input discipline in the brief.
module auxreq_chk #(
    parameter int LEN_W       = 5,
    parameter int MAX_TRIES   = 4,
    parameter int MAX_PAYLOAD = 16,
    parameter int WAIT_CYC    = 100000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic [15:0]      req_addr,
    input logic [LEN_W-1:0] req_len,
    input logic             ch_start,
    input logic [39:0]      ch_hdr,
    input logic             ch_done,
    input logic [1:0]       ch_status,
    input logic [7:0]       ch_reply,
    input logic             done,
    input logic [2:0]       res_err
);
    logic        in_txn;
    logic [15:0] addr_seen;
    int          starts;
    int          gap;
    logic        pend;
    logic        accept;

    assign accept = req_valid && !in_txn;

    // Track the open command, its address, attempts and the pause length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_txn    <= 1'b0;
            addr_seen <= '0;
            starts    <= 0;
            gap       <= 0;
            pend      <= 1'b0;
        end else begin
            if (accept) begin
                in_txn    <= 1'b1;
                addr_seen <= req_addr;
                starts    <= 0;
            end else begin
                if (done)
                    in_txn <= 1'b0;
                if (ch_start)
                    starts <= starts + 1;
            end
            if (accept) begin
                pend <= 1'b0;
            end else if (ch_done && ch_status == 2'd0 && ch_reply[1:0] == 2'd2) begin
                pend <= 1'b1;
                gap  <= 0;
            end else if (ch_start) begin
                pend <= 1'b0;
            end else if (pend && gap < WAIT_CYC + 2) begin
                gap <= gap + 1;
            end
        end
    end

    AST_HDR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ch_start |-> ch_hdr[15:0] == addr_seen); // R1

    AST_OVERSIZE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_kind == 2'd0 && int'(req_len) > MAX_PAYLOAD)
        |=> (done && res_err == 3'd5 && !ch_start)); // R3

    AST_BUSY_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_done && ch_status == 2'd2 && starts < MAX_TRIES) |=> ch_start); // R4

    AST_DEFER_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_start && pend) |-> gap == WAIT_CYC); // R5

    AST_ATTEMPT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        ch_start |-> starts < MAX_TRIES); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

endmodule

bind auxreq_engine auxreq_chk #(
    .LEN_W       (LEN_W),
    .MAX_TRIES   (MAX_TRIES),
    .MAX_PAYLOAD (MAX_PAYLOAD),
    .WAIT_CYC    (WAIT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .ch_start  (ch_start),
    .ch_hdr    (ch_hdr),
    .ch_done   (ch_done),
    .ch_status (ch_status),
    .ch_reply  (ch_reply),
    .done      (done),
    .res_err   (res_err)
);

// File: tb/auxreq_engine_tb.sv
// Bench: scripted channel model answering each header after LAT cycles,
// behavioural reference of attempts, gaps and results, checked per clock.
module auxreq_engine_tb;
    localparam int LEN_W = 5;
    localparam int W     = 6;
    localparam int LAT   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_kind = '0;
    logic [15:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_stop = 1'b0;
    logic [7:0]       req_wdata = '0;
    logic [LEN_W-1:0] req_bufsz = '0;
    logic             ch_start;
    logic [39:0]      ch_hdr;
    logic [LEN_W:0]   ch_msg_len;
    logic             ch_done = 1'b0;
    logic [1:0]       ch_status = '0;
    logic [7:0]       ch_reply = '0;
    logic [7:0]       ch_rdata = '0;
    logic [LEN_W-1:0] ch_rcount = '0;
    logic             done;
    logic [2:0]       res_err;
    logic [LEN_W-1:0] res_count;
    logic [7:0]       res_byte;

    always #2 clk = ~clk;

    auxreq_engine #(.LEN_W(LEN_W), .CLK_MHZ(1), .WAIT_US(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_len(req_len), .req_stop(req_stop),
        .req_wdata(req_wdata), .req_bufsz(req_bufsz), .ch_start(ch_start),
        .ch_hdr(ch_hdr), .ch_msg_len(ch_msg_len), .ch_done(ch_done),
        .ch_status(ch_status), .ch_reply(ch_reply), .ch_rdata(ch_rdata),
        .ch_rcount(ch_rcount), .done(done), .res_err(res_err),
        .res_count(res_count), .res_byte(res_byte)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    int q_st[$];
    int q_rp[$];
    int q_rd[$];
    int q_rc[$];
    int start_cyc[$];
    int exp_gap[$];
    int done_seen = 0;
    int done_cyc  = 0;
    int got_err, got_cnt, got_byte;
    logic [39:0] exp_hdr = '0;
    int exp_ml = 0;
    string cur_tag = "";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    task automatic rep(input int st, input int rp, input int rd, input int rc);
        q_st.push_back(st);
        q_rp.push_back(rp);
        q_rd.push_back(rd);
        q_rc.push_back(rc);
    endtask

    // Channel model and per-clock monitor.
    initial begin
        int wait_n;
        wait_n = -1;
        forever begin
            @(negedge clk);
            ch_done = 1'b0;
            if (wait_n == 0) begin
                ch_done = 1'b1;
                if (q_st.size() > 0) begin
                    ch_status = 2'(q_st.pop_front());
                    ch_reply  = 8'(q_rp.pop_front());
                    ch_rdata  = 8'(q_rd.pop_front());
                    ch_rcount = LEN_W'(q_rc.pop_front());
                end else begin
                    ch_status = 2'd1;
                end
                wait_n = -1;
            end else if (wait_n > 0) begin
                wait_n--;
            end
            if (rst_n && ch_start && done) check("R12", "start with done", 1, 0);
            if (ch_start) begin
                start_cyc.push_back(cyc);
                check({cur_tag, " R1 R2"}, "header", int'(ch_hdr[31:0]), int'(exp_hdr[31:0]));
                check({cur_tag, " R2"}, "byte4/len", int'({ch_hdr[39:32], 2'b00, ch_msg_len}),
                      int'({exp_hdr[39:32], 8'(exp_ml)}));
                wait_n = LAT - 1;
            end
            if (done) begin
                done_seen++;
                done_cyc = cyc;
                got_err  = int'(res_err);
                got_cnt  = int'(res_count);
                got_byte = int'(res_byte);
            end
        end
    end

    // Behavioural reference of one command over the scripted replies.
    task automatic model(input int kind, input int len, input int bufsz,
                         output int err, output int cnt, output int byt, output int n);
        err = -1; cnt = 0; byt = 0; n = 0;
        exp_gap.delete();
        if (kind == 0 && len > 16) begin
            err = 5;
            return;
        end
        for (int i = 0; i < 4 && err < 0; i++) begin
            int st, rp, rd, rc, cl, g, nat, ic;
            st = (i < q_st.size()) ? q_st[i] : 1;
            rp = (i < q_st.size()) ? q_rp[i] : 0;
            rd = (i < q_st.size()) ? q_rd[i] : 0;
            rc = (i < q_st.size()) ? q_rc[i] : 0;
            cl = (rc > bufsz) ? bufsz : rc;
            nat = rp % 4;
            ic = (rp / 4) % 4;
            g = 0;
            n++;
            if (st == 1) err = 1;
            else if (st == 3) err = 2;
            else if (st == 2) g = LAT + 1;
            else if (nat == 2) g = LAT + 1 + W;
            else if (nat != 0) err = (kind < 2) ? 2 : 4;
            else if (kind == 0) begin err = 0; cnt = len; end
            else if (kind == 1) begin
                if (cl == 0) err = 3;
                else begin err = 0; cnt = cl; end
            end
            else if (ic == 0) begin err = 0; cnt = cl; byt = (kind == 3) ? rd : 0; end
            else if (ic == 2) g = LAT + 1 + W;
            else err = 4;
            if (err < 0) exp_gap.push_back(g);
        end
        if (err < 0) begin
            err = (kind < 2) ? 2 : 4;
            void'(exp_gap.pop_back());
        end
    endtask

    task automatic txn(input string tag, input int kind, input int addr, input int len,
                       input bit stop, input int wd, input int bufsz);
        int e_err, e_cnt, e_byt, e_n, c0, b2, b3, waited;
        model(kind, len, bufsz, e_err, e_cnt, e_byt, e_n);
        case (kind)
            0: begin b2 = 8'h80; b3 = (((len + 4) % 16) * 16) + ((len + 15) % 16); exp_ml = len + 4; end
            1: begin b2 = 8'h90; b3 = 8'h40 + ((len + 15) % 16); exp_ml = 4; end
            2: begin b2 = stop ? 8'h00 : 8'h40; b3 = 8'h50; exp_ml = 5; end
            default: begin b2 = stop ? 8'h10 : 8'h50; b3 = 8'h40; exp_ml = 4; end
        endcase
        exp_hdr = {8'((kind == 2) ? wd : 0), 8'(b3), 8'(b2), 16'(addr)};
        cur_tag = tag;
        start_cyc.delete();
        done_seen = 0;
        @(negedge clk);
        req_kind = 2'(kind); req_addr = 16'(addr); req_len = LEN_W'(len);
        req_stop = stop; req_wdata = 8'(wd); req_bufsz = LEN_W'(bufsz);
        req_valid = 1'b1;
        c0 = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (done_seen == 0 && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        check(tag, "done seen", done_seen, 1);
        check(tag, "res_err", got_err, e_err);
        check(tag, "res_count R10", got_cnt, e_cnt);
        check(tag, "res_byte R9", got_byte, e_byt);
        check(tag, "attempts R7", start_cyc.size(), e_n);
        if (start_cyc.size() == e_n && e_n > 0) begin
            check(tag, "first start", start_cyc[0], c0 + 1);
            for (int i = 0; i + 1 < e_n; i++)
                check({tag, " R4 R5"}, "attempt gap", start_cyc[i + 1] - start_cyc[i], exp_gap[i]);
            check({tag, " R12"}, "done cycle", done_cyc, start_cyc[e_n - 1] + LAT + 1);
        end else if (e_n == 0) begin
            check({tag, " R3"}, "done cycle", done_cyc, c0 + 1);
        end
        @(negedge clk);
        check({tag, " R12"}, "done single pulse", int'(done), 0);
        check({tag, " R12"}, "result held", int'(res_err), e_err);
        q_st.delete(); q_rp.delete(); q_rd.delete(); q_rc.delete();
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "reset done", int'(done), 0);
        check("R12", "reset ch_start", int'(ch_start), 0);
        check("R12", "reset res_err", int'(res_err), 0);

        rep(0, 8'h00, 0, 0);
        txn("R1 R10 native write", 0, 16'h1234, 4, 1'b1, 0, 8);
        rep(0, 8'h00, 0, 16);
        txn("R2 native write max", 0, 16'hBEEF, 16, 1'b1, 0, 16);
        txn("R3 native write oversize", 0, 16'h0101, 17, 1'b1, 0, 16);
        rep(0, 8'h00, 8'h11, 9);
        txn("R10 native read", 1, 16'h0200, 16, 1'b1, 0, 16);
        rep(0, 8'h00, 0, 8);
        txn("R10 native read clamp", 1, 16'h0202, 8, 1'b1, 0, 3);
        rep(0, 8'h00, 0, 0);
        txn("R11 native read zero", 1, 16'h0204, 2, 1'b1, 0, 4);
        rep(2, 0, 0, 0); rep(2, 0, 0, 0); rep(0, 8'h00, 0, 2);
        txn("R4 busy then ack", 1, 16'h0300, 2, 1'b1, 0, 4);
        rep(1, 0, 0, 0);
        txn("R4 timeout", 0, 16'h0301, 1, 1'b1, 0, 4);
        rep(3, 0, 0, 0);
        txn("R4 channel error", 1, 16'h0302, 1, 1'b1, 0, 4);
        rep(0, 8'h02, 0, 0); rep(0, 8'h00, 0, 3);
        txn("R5 defer then ack", 1, 16'h0400, 3, 1'b1, 0, 8);
        rep(0, 8'h01, 0, 0);
        txn("R6 native nack", 0, 16'h0500, 2, 1'b1, 0, 4);
        rep(0, 8'h03, 0, 0);
        txn("R6 native code3", 1, 16'h0501, 2, 1'b1, 0, 4);
        rep(0, 8'h01, 0, 0);
        txn("R6 i2c native nack", 3, 16'h0050, 1, 1'b1, 0, 1);
        rep(2, 0, 0, 0); rep(2, 0, 0, 0); rep(2, 0, 0, 0); rep(2, 0, 0, 0);
        txn("R7 busy exhausted", 0, 16'h0600, 1, 1'b1, 0, 4);
        rep(0, 8'h08, 0, 0); rep(0, 8'h02, 0, 0); rep(0, 8'h08, 0, 0); rep(0, 8'h08, 0, 0);
        txn("R7 R9 i2c defer exhausted", 3, 16'h0050, 1, 1'b1, 0, 1);
        rep(0, 8'h00, 0, 1);
        txn("R8 i2c write mot", 2, 16'h0050, 1, 1'b0, 8'h3C, 1);
        rep(0, 8'h00, 8'h77, 1);
        txn("R8 i2c read mot", 3, 16'h0051, 1, 1'b0, 0, 1);
        rep(0, 8'h08, 8'h00, 1); rep(0, 8'h00, 8'hA5, 1);
        txn("R9 i2c defer then ack", 3, 16'h0050, 1, 1'b1, 0, 1);
        rep(0, 8'h04, 8'h99, 1);
        txn("R9 i2c nack", 3, 16'h0050, 1, 1'b1, 0, 1);
        rep(0, 8'h06, 8'h99, 1); rep(0, 8'h00, 8'h5A, 1);
        txn("R9 i2c field ignored on native defer", 3, 16'h0052, 1, 1'b1, 0, 1);
        rep(0, 8'h0C, 8'h99, 1);
        txn("R9 i2c code3", 2, 16'h0053, 1, 1'b1, 8'h12, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule